// File: doc/BRIEF.md
# Inline Storage Crypto Key-Slot and Mode Controller

This block is the control plane of an encryption engine placed in the data path of a storage controller. Software loads cipher keys into a table of slots over a small valid/ready register bus and gives each storage partition a crypto mode. Each mode is built from two enable bits, one for the write (encrypt) direction and one for the read (decrypt) direction. For every storage request, which names a partition, a direction, a key slot, a cipher mode and a key length, the block answers one cycle later. The answer is either the key and cipher selection for the AES datapath or a bypass indication.

A mode change on a partition that still has transactions in flight is held pending until that partition drains. Other partitions keep working through the change. A request that would need a key that is missing or too short is forced to bypass and flagged. The fault is also latched in a status register, which software reads after each transfer and which clears when read. A reset or a power-collapse pulse wipes every key, mode, pending change and status bit.

Top module: `inline_key_ctrl`

## Requirements
- R1: After reset or a power-collapse cycle, every partition is in bypass (mode reads 0), every key slot is unloaded, and status and enable read 0. Until software reloads them, requests are answered with bypass and no key.
- R2: A request is answered on the cfg outputs exactly one clock after reqValid. Mode bit 0 enables crypto for writes (reqDir=0) and mode bit 1 enables it for reads (reqDir=1). When crypto applies, cfgBypass=0, cfgKey is the slot key, and cfgAlg/cfgKeyLen echo the request.
- R3: Each partition counts its outstanding requests, incremented by reqValid and decremented by doneValid. A mode write (address 0x10+partition, data bits [1:0]) becomes pending and is applied only in a cycle where the count is zero and no new request targets that partition. Mode readback shows the active mode in bits [1:0] and the pending flag in bit 4. Other partitions are not affected.
- R4: Words 0 to 7 (addresses 0x00 to 0x07) stage a 256-bit key, with word i at bits [32i+31:32i]. A write to 0x08 commits the staged key into slot data[4:0]. When data bit 8 is 1 the whole key is stored; when it is 0 only words 0 to 3 are kept and the upper 128 bits are zero.
- R5: A crypto-enabled request that names a slot not loaded since the last wipe is answered with cfgBypass=1 and cfgErr=1, and sets status bit 0.
- R6: A crypto-enabled request that asks for a 256-bit key (reqKeyLen=1) from a loaded slot that was committed as 128-bit is answered with cfgBypass=1 and cfgErr=1, and sets status bit 1.
- R7: A read of status (0x20) returns the latched bits and clears them. A fault that occurs in the same cycle as the read is kept for the next read.
- R8: errIrq is high while any status bit is set whose enable bit (0x24, bits [1:0]) is set.
- R9: Key material never appears on the register bus. Staging words, the commit register and unmapped addresses read as zero.
- R10: While pwrCollapse is high, regReady is low, no request or read is answered, and all secret and configuration state is wiped.
- R11: rspValid pulses exactly one clock after an accepted read and never after a write.
- R12: A bypassed answer always carries an all-zero cfgKey. A request whose direction is not enabled raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pwrCollapse | input | 1 | Power-collapse wipe strobe |
| regValid | input | 1 | Register access request |
| regReady | output | 1 | Register bus can accept |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 8 | Register address |
| regWdata | input | 32 | Write data |
| rspValid | output | 1 | Read data valid |
| rspData | output | 32 | Read data |
| reqValid | input | 1 | Storage request strobe |
| reqPart | input | 2 | Request partition |
| reqDir | input | 1 | 0 = write/encrypt, 1 = read/decrypt |
| reqKeyIdx | input | 5 | Key slot index |
| reqAlg | input | 1 | Cipher mode, 0 = ECB, 1 = XTS |
| reqKeyLen | input | 1 | 0 = 128-bit, 1 = 256-bit |
| doneValid | input | 1 | Transaction completion strobe |
| donePart | input | 2 | Partition of the completed transaction |
| cfgValid | output | 1 | Answer valid |
| cfgBypass | output | 1 | Pass data without crypto |
| cfgErr | output | 1 | Request forced to bypass by a key fault |
| cfgAlg | output | 1 | Cipher mode echoed |
| cfgKeyLen | output | 1 | Key length echoed |
| cfgKey | output | 256 | Selected key, zero when bypassed |
| errIrq | output | 1 | Enabled error pending |

## Verification
The assertions check, on every cycle, that a bypassed answer carries no key, that every error answer is a bypass, that answers and read responses line up one clock after their causes, and that nothing is answered during a power collapse or with old modes right after one. Other behaviours need the bench's scenarios, because they depend on sequences of events. These are the deferral of a mode change until a partition drains, the truncation of 128-bit keys, read-to-clear racing against a new fault, and the loss of keys after a wipe. Random requests over mixed modes, slots and lengths are compared against a bench model of the key table.

// File: rtl/ikc_pkg.sv
package ikc_pkg;
  localparam int SLOTS  = 32;
  localparam int PARTS  = 4;
  localparam int KEYW   = 256;
  localparam int WORDW  = 32;
  localparam int CNTW   = 4;
  localparam int ADDRW  = 8;
  localparam int ERRW   = 2;
  localparam int SLOTW  = $clog2(SLOTS);
  localparam int PARTW  = $clog2(PARTS);
  localparam int NWORDS = KEYW / WORDW;
  localparam int WSELW  = $clog2(NWORDS);

  localparam logic [ADDRW-1:0] ADDR_COMMIT = 8'h08;
  localparam logic [ADDRW-1:0] ADDR_MODE   = 8'h10;
  localparam logic [ADDRW-1:0] ADDR_STATUS = 8'h20;
  localparam logic [ADDRW-1:0] ADDR_ENABLE = 8'h24;

  typedef struct packed {
    logic             stageWe;
    logic [WSELW-1:0] stageSel;
    logic [WORDW-1:0] data;
    logic             commit;
    logic             commitWide;
    logic [SLOTW-1:0] commitSlot;
    logic             modeWe;
    logic [PARTW-1:0] modePart;
    logic [1:0]       modeVal;
  } ikcStrobe_t;
endpackage

// File: rtl/ikc_ctrl.sv
module ikc_ctrl
  import ikc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wipe,
  input  logic                  regValid,
  input  logic                  regWrite,
  input  logic [ADDRW-1:0]      regAddr,
  input  logic [WORDW-1:0]      regWdata,
  output logic                  regReady,
  output logic                  rspValid,
  output logic [WORDW-1:0]      rspData,
  input  logic [ERRW-1:0]       errSet,
  input  logic [PARTS-1:0][1:0] modeRd,
  input  logic [PARTS-1:0]      pendRd,
  output ikcStrobe_t            strobe,
  output logic                  errIrq
);
  logic [ERRW-1:0]  statusQ, enQ;
  logic [WORDW-1:0] rdMux;
  logic accept, wr, rd, isMode, statusClr;

  assign regReady  = !wipe;
  assign accept    = regValid && !wipe;
  assign wr        = accept && regWrite;
  assign rd        = accept && !regWrite;
  assign isMode    = (regAddr[ADDRW-1:4] == ADDR_MODE[ADDRW-1:4]) &&
                     ({4'b0, regAddr[3:0]} < ADDRW'(PARTS));
  assign statusClr = rd && (regAddr == ADDR_STATUS);
  assign errIrq    = |(statusQ & enQ);

  always_comb begin
    strobe = '0;
    strobe.data = regWdata;
    if (wr && (regAddr < ADDRW'(NWORDS))) begin
      strobe.stageWe  = 1'b1;
      strobe.stageSel = regAddr[WSELW-1:0];
    end
    if (wr && (regAddr == ADDR_COMMIT)) begin
      strobe.commit     = 1'b1;
      strobe.commitSlot = regWdata[SLOTW-1:0];
      strobe.commitWide = regWdata[8];
    end
    if (wr && isMode) begin
      strobe.modeWe   = 1'b1;
      strobe.modePart = regAddr[PARTW-1:0];
      strobe.modeVal  = regWdata[1:0];
    end
  end

  // Only status, enable and mode registers are readable; key paths read zero.
  always_comb begin
    rdMux = '0;
    if (regAddr == ADDR_STATUS)      rdMux = WORDW'(statusQ);
    else if (regAddr == ADDR_ENABLE) rdMux = WORDW'(enQ);
    else if (isMode)
      rdMux = WORDW'({pendRd[regAddr[PARTW-1:0]], 2'b00, modeRd[regAddr[PARTW-1:0]]});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ  <= '0;
      enQ      <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else if (wipe) begin
      statusQ  <= '0;
      enQ      <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      statusQ  <= (statusClr ? '0 : statusQ) | errSet;
      if (wr && (regAddr == ADDR_ENABLE)) enQ <= regWdata[ERRW-1:0];
      rspValid <= rd;
      rspData  <= rd ? rdMux : '0;
    end
  end
endmodule

// File: rtl/ikc_datapath.sv
module ikc_datapath
  import ikc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wipe,
  input  ikcStrobe_t            strobe,
  input  logic                  reqValid,
  input  logic [PARTW-1:0]      reqPart,
  input  logic                  reqDir,
  input  logic [SLOTW-1:0]      reqKeyIdx,
  input  logic                  reqAlg,
  input  logic                  reqKeyLen,
  input  logic                  doneValid,
  input  logic [PARTW-1:0]      donePart,
  output logic                  cfgValid,
  output logic                  cfgBypass,
  output logic                  cfgErr,
  output logic                  cfgAlg,
  output logic                  cfgKeyLen,
  output logic [KEYW-1:0]       cfgKey,
  output logic [ERRW-1:0]       errSet,
  output logic [PARTS-1:0][1:0] modeRd,
  output logic [PARTS-1:0]      pendRd
);
  logic [KEYW-1:0]              keyMem [SLOTS];
  logic [SLOTS-1:0]             keyOk, keyWide;
  logic [NWORDS-1:0][WORDW-1:0] stageQ;
  logic reqLive, useCrypto, missKey, lenBad, hit, good;
  logic [1:0] curMode;

  assign reqLive = reqValid && !wipe;

  // Per-partition mode, deferred mode and outstanding counter.
  for (genvar p = 0; p < PARTS; p++) begin : g_part
    logic [1:0]      modeQ, pendModeQ;
    logic            pendQ;
    logic [CNTW-1:0] cntQ;
    logic            reqHere, doneHere;
    assign reqHere  = reqLive && (reqPart == PARTW'(p));
    assign doneHere = doneValid && (donePart == PARTW'(p)) && (cntQ != '0);
    assign modeRd[p] = modeQ;
    assign pendRd[p] = pendQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        modeQ <= '0; pendModeQ <= '0; pendQ <= 1'b0; cntQ <= '0;
      end else if (wipe) begin
        modeQ <= '0; pendModeQ <= '0; pendQ <= 1'b0; cntQ <= '0;
      end else begin
        if (reqHere && !doneHere)      cntQ <= cntQ + CNTW'(1);
        else if (doneHere && !reqHere) cntQ <= cntQ - CNTW'(1);
        if (strobe.modeWe && (strobe.modePart == PARTW'(p))) begin
          pendQ     <= 1'b1;
          pendModeQ <= strobe.modeVal;
        end else if (pendQ && (cntQ == '0) && !reqHere) begin
          modeQ <= pendModeQ;
          pendQ <= 1'b0;
        end
      end
    end
  end

  // Key staging and slot table.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageQ <= '0; keyOk <= '0; keyWide <= '0;
      for (int s = 0; s < SLOTS; s++) keyMem[s] <= '0;
    end else if (wipe) begin
      stageQ <= '0; keyOk <= '0; keyWide <= '0;
      for (int s = 0; s < SLOTS; s++) keyMem[s] <= '0;
    end else begin
      if (strobe.stageWe) stageQ[strobe.stageSel] <= strobe.data;
      if (strobe.commit) begin
        keyMem[strobe.commitSlot]  <= strobe.commitWide ? stageQ
                                      : {{(KEYW/2){1'b0}}, stageQ[NWORDS/2-1:0]};
        keyOk[strobe.commitSlot]   <= 1'b1;
        keyWide[strobe.commitSlot] <= strobe.commitWide;
      end
    end
  end

  // Request lookup.
  assign curMode   = modeRd[reqPart];
  assign useCrypto = reqDir ? curMode[1] : curMode[0];
  assign missKey   = !keyOk[reqKeyIdx];
  assign lenBad    = reqKeyLen && !keyWide[reqKeyIdx];
  assign hit       = reqLive && useCrypto;
  assign good      = hit && !missKey && !lenBad;
  assign errSet    = {hit && !missKey && lenBad, hit && missKey};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgValid <= 1'b0; cfgBypass <= 1'b1; cfgErr <= 1'b0;
      cfgAlg <= 1'b0; cfgKeyLen <= 1'b0; cfgKey <= '0;
    end else begin
      cfgValid  <= reqLive;
      cfgBypass <= !good;
      cfgErr    <= |errSet;
      cfgAlg    <= reqAlg;
      cfgKeyLen <= reqKeyLen;
      cfgKey    <= good ? keyMem[reqKeyIdx] : '0;
    end
  end
endmodule

// File: rtl/inline_key_ctrl.sv
module inline_key_ctrl
  import ikc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrCollapse,
  input  logic              regValid,
  output logic              regReady,
  input  logic              regWrite,
  input  logic [ADDRW-1:0]  regAddr,
  input  logic [WORDW-1:0]  regWdata,
  output logic              rspValid,
  output logic [WORDW-1:0]  rspData,
  input  logic              reqValid,
  input  logic [PARTW-1:0]  reqPart,
  input  logic              reqDir,
  input  logic [SLOTW-1:0]  reqKeyIdx,
  input  logic              reqAlg,
  input  logic              reqKeyLen,
  input  logic              doneValid,
  input  logic [PARTW-1:0]  donePart,
  output logic              cfgValid,
  output logic              cfgBypass,
  output logic              cfgErr,
  output logic              cfgAlg,
  output logic              cfgKeyLen,
  output logic [KEYW-1:0]   cfgKey,
  output logic              errIrq
);
  ikcStrobe_t            strobe;
  logic [ERRW-1:0]       errSet;
  logic [PARTS-1:0][1:0] modeRd;
  logic [PARTS-1:0]      pendRd;

  ikc_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .wipe(pwrCollapse),
    .regValid(regValid), .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
    .regReady(regReady), .rspValid(rspValid), .rspData(rspData),
    .errSet(errSet), .modeRd(modeRd), .pendRd(pendRd),
    .strobe(strobe), .errIrq(errIrq)
  );

  ikc_datapath i_dp (
    .clk(clk), .rstN(rstN), .wipe(pwrCollapse), .strobe(strobe),
    .reqValid(reqValid), .reqPart(reqPart), .reqDir(reqDir), .reqKeyIdx(reqKeyIdx),
    .reqAlg(reqAlg), .reqKeyLen(reqKeyLen), .doneValid(doneValid), .donePart(donePart),
    .cfgValid(cfgValid), .cfgBypass(cfgBypass), .cfgErr(cfgErr), .cfgAlg(cfgAlg),
    .cfgKeyLen(cfgKeyLen), .cfgKey(cfgKey), .errSet(errSet),
    .modeRd(modeRd), .pendRd(pendRd)
  );
endmodule

// File: rtl/ikc_checker.sv
module ikc_checker
  import ikc_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            pwrCollapse,
  input logic            regValid,
  input logic            regReady,
  input logic            regWrite,
  input logic            rspValid,
  input logic            reqValid,
  input logic            cfgValid,
  input logic            cfgBypass,
  input logic            cfgErr,
  input logic [KEYW-1:0] cfgKey
);
  assert_bypass_zero_key_R12: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid && cfgBypass |-> cfgKey == '0);

  assert_err_forces_bypass_R5: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid && cfgErr |-> cfgBypass);

  assert_cfg_follows_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |-> $past(reqValid));

  assert_rsp_only_reads_R11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(regValid && regReady && !regWrite));

  assert_collapse_silent_R10: assert property (@(posedge clk) disable iff (!rstN)
    pwrCollapse |=> !cfgValid && !rspValid);

  assert_wiped_bypass_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(pwrCollapse, 2) && !$past(pwrCollapse) && cfgValid |-> cfgBypass && !cfgErr);
endmodule

bind inline_key_ctrl ikc_checker i_chk (
  .clk(clk), .rstN(rstN), .pwrCollapse(pwrCollapse), .regValid(regValid),
  .regReady(regReady), .regWrite(regWrite), .rspValid(rspValid), .reqValid(reqValid),
  .cfgValid(cfgValid), .cfgBypass(cfgBypass), .cfgErr(cfgErr), .cfgKey(cfgKey)
);

// File: tb/test_inline_key_ctrl.sv
`timescale 1ns/1ps
module test_inline_key_ctrl;
  logic clk = 1'b0, rstN = 1'b0, pwrCollapse = 1'b0;
  logic regValid = 1'b0, regWrite = 1'b0;
  logic [7:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic regReady, rspValid;
  logic [31:0] rspData;
  logic reqValid = 1'b0, reqDir = 1'b0, reqAlg = 1'b0, reqKeyLen = 1'b0;
  logic [1:0] reqPart = '0, donePart = '0;
  logic [4:0] reqKeyIdx = '0;
  logic doneValid = 1'b0;
  logic cfgValid, cfgBypass, cfgErr, cfgAlg, cfgKeyLen, errIrq;
  logic [255:0] cfgKey;

  int testsRun = 0, testsFailed = 0;
  bit finished = 0;

  logic [255:0] mKey [32];
  bit mOk [32];
  bit mWide [32];
  logic [1:0] mMode [4];
  logic [1:0] mStatus = '0;

  always #2.5 clk = ~clk;

  inline_key_ctrl i_inline_key_ctrl (
    .clk(clk), .rstN(rstN), .pwrCollapse(pwrCollapse),
    .regValid(regValid), .regReady(regReady), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .rspValid(rspValid), .rspData(rspData),
    .reqValid(reqValid), .reqPart(reqPart), .reqDir(reqDir), .reqKeyIdx(reqKeyIdx),
    .reqAlg(reqAlg), .reqKeyLen(reqKeyLen), .doneValid(doneValid), .donePart(donePart),
    .cfgValid(cfgValid), .cfgBypass(cfgBypass), .cfgErr(cfgErr), .cfgAlg(cfgAlg),
    .cfgKeyLen(cfgKeyLen), .cfgKey(cfgKey), .errIrq(errIrq)
  );

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regValid = 1; regWrite = 1; regAddr = a; regWdata = d;
    @(negedge clk);
    regValid = 0; regWrite = 0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    regValid = 1; regWrite = 0; regAddr = a;
    @(negedge clk);
    regValid = 0;
    d = rspData; v = rspValid;
  endtask

  function automatic void wipeModel();
    for (int s = 0; s < 32; s++) begin mOk[s] = 0; mWide[s] = 0; mKey[s] = '0; end
    for (int p = 0; p < 4; p++) mMode[p] = 2'd0;
    mStatus = '0;
  endfunction

  task automatic loadKey(input int slot, input bit wide);
    logic [255:0] k;
    for (int w = 0; w < 8; w++) begin
      k[w*32 +: 32] = $urandom;
      busWrite(8'(w), k[w*32 +: 32]);
    end
    busWrite(8'h08, {23'b0, wide, 3'b0, 5'(slot)});
    mOk[slot] = 1; mWide[slot] = wide;
    mKey[slot] = wide ? k : {128'b0, k[127:0]};
  endtask

  task automatic setMode(input int p, input logic [1:0] m);
    busWrite(8'h10 + 8'(p), {30'b0, m});
    idle(2);
    mMode[p] = m;
  endtask

  // Expected answer from the requirements (R2, R5, R6, R12).
  task automatic expect_cfg(input int p, input bit dir, input int idx, input bit len,
                            output bit eByp, output bit eErr, output logic [255:0] eKey,
                            output logic [1:0] eSt);
    bit useC = dir ? mMode[p][1] : mMode[p][0];
    eByp = 1; eErr = 0; eKey = '0; eSt = '0;
    if (useC) begin
      if (!mOk[idx]) begin eErr = 1; eSt = 2'b01; end
      else if (len && !mWide[idx]) begin eErr = 1; eSt = 2'b10; end
      else begin eByp = 0; eKey = mKey[idx]; end
    end
  endtask

  task automatic doReq(input string tag, input int p, input bit dir, input int idx,
                       input bit alg, input bit len, input bit keepOpen);
    bit eByp, eErr; logic [255:0] eKey; logic [1:0] eSt;
    expect_cfg(p, dir, idx, len, eByp, eErr, eKey, eSt);
    @(negedge clk);
    reqValid = 1; reqPart = 2'(p); reqDir = dir; reqKeyIdx = 5'(idx); reqAlg = alg; reqKeyLen = len;
    @(negedge clk);
    reqValid = 0;
    check({tag, " valid"}, 256'(cfgValid), 256'(1));
    check({tag, " bypass"}, 256'(cfgBypass), 256'(eByp));
    check({tag, " err"}, 256'(cfgErr), 256'(eErr));
    check({tag, " key"}, cfgKey, eKey);
    check({tag, " alg/len echo"}, 256'({cfgAlg, cfgKeyLen}), 256'({alg, len}));
    mStatus |= eSt;
    if (!keepOpen) begin
      doneValid = 1; donePart = 2'(p);
      @(negedge clk);
      doneValid = 0;
    end
  endtask

  task automatic doDone(input int p);
    @(negedge clk);
    doneValid = 1; donePart = 2'(p);
    @(negedge clk);
    doneValid = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    testsFailed++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] d; logic v;
    void'($urandom(32'd4242));
    wipeModel();
    idle(3);
    rstN = 1;
    idle(1);

    // R1: reset state
    check("R1 cfgValid after reset", 256'(cfgValid), 256'(0));
    check("R1 irq after reset", 256'(errIrq), 256'(0));
    check("R10 ready when idle", 256'(regReady), 256'(1));
    for (int p = 0; p < 4; p++) begin
      busRead(8'h10 + 8'(p), d, v);
      check("R1 mode reads bypass", 256'(d), 256'(0));
    end
    busRead(8'h20, d, v);
    check("R1 status zero", 256'(d), 256'(0));
    check("R11 rspValid after read", 256'(v), 256'(1));
    doReq("R1 bypass no keys", 0, 0, 5, 0, 1, 0);

    // R2, R4, R5, R6, R12
    loadKey(3, 1);
    loadKey(7, 0);
    setMode(0, 2'd1);
    doReq("R2 encrypt wide", 0, 0, 3, 1, 1, 0);
    doReq("R2 decrypt disabled R12", 0, 1, 3, 0, 1, 0);
    doReq("R4 narrow key upper zero", 0, 0, 7, 1, 0, 0);
    doReq("R6 length mismatch", 0, 0, 7, 0, 1, 0);
    doReq("R5 unloaded slot", 0, 0, 9, 0, 0, 0);

    // R7, R8
    check("R8 irq masked", 256'(errIrq), 256'(0));
    busRead(8'h20, d, v);
    check("R7 status latched", 256'(d), 256'(mStatus));
    busRead(8'h20, d, v);
    check("R7 status cleared", 256'(d), 256'(0));
    mStatus = '0;
    busWrite(8'h24, 32'h1);
    doReq("R8 fault for irq", 0, 0, 11, 0, 0, 0);
    idle(1);
    check("R8 irq raised", 256'(errIrq), 256'(1));
    busRead(8'h20, d, v);
    idle(1);
    check("R8 irq drops after clear", 256'(errIrq), 256'(0));
    mStatus = '0;
    // R7: fault in the same cycle as the clearing read
    @(negedge clk);
    reqValid = 1; reqPart = 0; reqDir = 0; reqKeyIdx = 5'd20; reqKeyLen = 0;
    regValid = 1; regWrite = 0; regAddr = 8'h20;
    @(negedge clk);
    reqValid = 0; regValid = 0;
    check("R7 read during fault returns old", 256'(rspData), 256'(0));
    doDone(0);
    busRead(8'h20, d, v);
    check("R7 same-cycle fault kept", 256'(d), 256'(1));

    // R9, R11
    busWrite(8'h00, 32'hDEADBEEF);
    check("R11 no rsp after write", 256'(rspValid), 256'(0));
    busRead(8'h00, d, v);
    check("R9 staging reads zero", 256'(d), 256'(0));
    busRead(8'h08, d, v);
    check("R9 commit reads zero", 256'(d), 256'(0));
    busRead(8'h30, d, v);
    check("R9 unmapped reads zero", 256'(d), 256'(0));
    busRead(8'h24, d, v);
    check("R8 enable readback", 256'(d), 256'(1));

    // R3: deferred mode change
    setMode(1, 2'd3);
    doReq("R3 open request", 1, 0, 3, 0, 1, 1);
    busWrite(8'h11, 32'h0);
    idle(2);
    busRead(8'h11, d, v);
    check("R3 change pending", 256'(d), 256'(32'h13));
    doReq("R3 old mode still used", 1, 1, 3, 1, 1, 1);
    setMode(2, 2'd2);
    busRead(8'h12, d, v);
    check("R3 other partition applies", 256'(d), 256'(32'h02));
    doDone(1);
    idle(2);
    busRead(8'h11, d, v);
    check("R3 still pending one open", 256'(d), 256'(32'h13));
    doDone(1);
    idle(2);
    busRead(8'h11, d, v);
    check("R3 applied after drain", 256'(d), 256'(32'h00));
    mMode[1] = 2'd0;
    doReq("R3 new mode bypass", 1, 0, 3, 0, 1, 0);

    // R10, R1: power collapse wipe
    @(negedge clk);
    pwrCollapse = 1; regValid = 1; regWrite = 1; regAddr = 8'h13; regWdata = 32'h3;
    #1;
    check("R10 ready low in collapse", 256'(regReady), 256'(0));
    @(negedge clk);
    pwrCollapse = 0; regValid = 0; regWrite = 0;
    wipeModel();
    busRead(8'h13, d, v);
    check("R10 write during collapse ignored", 256'(d), 256'(0));
    busRead(8'h10, d, v);
    check("R1 mode wiped", 256'(d), 256'(0));
    busRead(8'h24, d, v);
    check("R1 enable wiped", 256'(d), 256'(0));
    setMode(0, 2'd1);
    doReq("R1 key wiped", 0, 0, 3, 0, 1, 0);
    busRead(8'h20, d, v);
    check("R1 wiped key faults", 256'(d), 256'(mStatus));
    mStatus = '0;

    // Random phase
    for (int s = 0; s < 6; s++) loadKey(s, 1'($urandom_range(0, 1)));
    for (int p = 0; p < 4; p++) setMode(p, 2'($urandom_range(0, 3)));
    for (int i = 0; i < 60; i++)
      doReq("R2 random", $urandom_range(0, 3), 1'($urandom_range(0, 1)),
            $urandom_range(0, 7), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 0);
    busRead(8'h20, d, v);
    check("R5 R6 random status", 256'(d), 256'(mStatus));

    report();
  end
endmodule